// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block steps a high-speed serial PHY through its clock, reset and supply controls in a fixed order. It owns eight level-type enable outputs, split into a link group (link clock, secondary bus clock, link reset release, secondary bus reset release) and a power group (external reference clock, PHY clock, PHY reset release, bus supply). Four one-cycle commands drive it: init and exit act on the link group, power-on and power-off act on the power group. Each bring-up step raises one enable and then waits for the matching resource to answer with an acknowledge pulse or a failure pulse, within a programmable number of cycles.

A failed or timed-out bring-up step drops its own enable and then releases the steps that had already completed, newest first, before reporting an error with the step index and the cause. Tear-down commands release the group in the mirror order, one control per cycle, without waiting for any answer. Two straps say whether the external reference clock and the bus supply are fitted; an absent one is never driven. After a clean init, and unless the legacy strap is set, the block pulses a start signal for the downstream parameter loader.

While a sequence runs the block reports busy and refuses any command, flagging the refusal with a pulse. Clock generators and regulators are outside the block and appear only as acknowledge and failure inputs.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset all enables are low, and busy, done, error, reject and loader-start are low.
- R2: Power-on raises en_o[0] (external clock), en_o[1] (PHY clock), en_o[2] (PHY reset release), en_o[3] (bus supply) in that order, raising each only after ack_i of the previous fitted step has been seen.
- R3: Power-off lowers en_o[3], en_o[2], en_o[1], en_o[0] in that order, one per cycle, so done_o appears on the fifth cycle after the command cycle, without waiting for any answer.
- R4: Init raises en_o[4] (link clock), en_o[5] (secondary bus clock), en_o[6] (link reset release), en_o[7] (secondary bus reset release) in that order with the same handshake; exit lowers en_o[7], en_o[6], en_o[5], en_o[4] in that order, one per cycle.
- R5: With ext_clk_fitted_i low, en_o[0] is never raised during power-on; with bus_sup_fitted_i low, en_o[3] is never raised; the other steps proceed.
- R6: When fail_i of the step being waited on is high, that step's enable drops on the next cycle, the earlier steps of the sequence are lowered newest first one per cycle, and done_o and err_o pulse together with err_step_o holding the failed step index (0 to 3 within the group) and err_tmo_o low.
- R7: A step whose answer has not arrived after the wait cycle numbered tmo_limit_i (counting from 0) fails in the same way with err_tmo_o high.
- R8: busy_o is high from the cycle after an accepted command until done_o; a command arriving while busy, or two or more commands in the same cycle, raises reject_o for one cycle and changes no enable.
- R9: load_o pulses together with done_o after an init that ends without error while legacy_i is low; it stays low in legacy mode and after any other command.
- R10: done_o is a one-cycle pulse; err_step_o and err_tmo_o hold their values until the next accepted command.
- R11: fail_i and ack_i in the same cycle count as a failure; an acknowledge seen in wait cycle number tmo_limit_i is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_init_i | input | 1 | Bring up the link group (one-cycle pulse) |
| cmd_exit_i | input | 1 | Tear down the link group |
| cmd_on_i | input | 1 | Bring up the power group |
| cmd_off_i | input | 1 | Tear down the power group |
| ext_clk_fitted_i | input | 1 | External reference clock is present |
| bus_sup_fitted_i | input | 1 | Bus supply is present |
| legacy_i | input | 1 | Legacy mode: no loader start after init |
| tmo_limit_i | input | TMO_W (8) | Last wait cycle index in which an answer is accepted |
| ack_i | input | 2*N_STEP (8) | Per-resource acknowledge pulses |
| fail_i | input | 2*N_STEP (8) | Per-resource failure pulses |
| en_o | output | 2*N_STEP (8) | Per-resource enable / release levels |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Sequence finished (one-cycle pulse) |
| err_o | output | 1 | Sequence finished with an error (pulse with done_o) |
| err_step_o | output | $clog2(N_STEP) (2) | Index of the failed step within its group |
| err_tmo_o | output | 1 | Failure cause was a timeout |
| reject_o | output | 1 | A command was refused (one-cycle pulse) |
| load_o | output | 1 | Start the parameter loader (one-cycle pulse) |

## Verification
The hardest situation to reach is a failure deep in a bring-up, where the unwind must touch exactly the steps already completed while skipped optional steps stay untouched, and the timeout boundary where an acknowledge lands in the very last allowed wait cycle. The bench reaches these with a per-resource responder that answers each rising enable after a chosen delay with an acknowledge, a failure, both at once or silence, so a single power-on can be made to break at any chosen step and cycle. Commands injected mid-sequence and simultaneous commands in idle exercise the refusal path, while a cycle-by-cycle behavioural model follows every output.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    OP_INIT = 2'd0,
    OP_EXIT = 2'd1,
    OP_ON   = 2'd2,
    OP_OFF  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DOWN  = 2'd3
  } st_e;

  // Bring-up commands walk the group upwards, tear-down commands downwards.
  function automatic logic op_is_up(op_e op);
    return (op == OP_INIT) || (op == OP_ON);
  endfunction

  // Link group commands act on the upper half of the enable vector.
  function automatic logic op_is_link(op_e op);
    return (op == OP_INIT) || (op == OP_EXIT);
  endfunction

  // Position of a step in the flat enable vector.
  function automatic int unsigned flat_bit(op_e op, int unsigned idx, int unsigned n_step);
    return op_is_link(op) ? (n_step + idx) : idx;
  endfunction

  // First power step is the optional reference clock, last is the optional supply.
  function automatic logic step_fitted(op_e op, int unsigned idx, int unsigned last,
                                       logic ext_fit, logic sup_fit);
    if (op_is_link(op)) return 1'b1;
    if (idx == 0)       return ext_fit;
    if (idx == last)    return sup_fit;
    return 1'b1;
  endfunction

endpackage

// File: rtl/phy_seq_cmd_gate.sv
module phy_seq_cmd_gate
  import phy_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_init,
  input  logic cmd_exit,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic idle,
  output logic accept,
  output op_e  accept_op,
  output logic reject_q
);

  logic [3:0] req;
  logic       any_req;
  logic       single_req;

  always_comb begin
    req        = {cmd_off, cmd_on, cmd_exit, cmd_init};
    any_req    = |req;
    single_req = $onehot(req);
    accept     = idle && single_req;
    if (cmd_init)      accept_op = OP_INIT;
    else if (cmd_exit) accept_op = OP_EXIT;
    else if (cmd_on)   accept_op = OP_ON;
    else               accept_op = OP_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject_q <= 1'b0;
    else        reject_q <= any_req && !(idle && single_req);
  end

endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (start)                  cnt_q <= '0;
    else if (run && cnt_q != limit)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == limit);

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int N_STEP = 4,
  localparam int N_BIT = 2 * N_STEP,
  localparam int IDX_W = $clog2(N_STEP),
  localparam int BIT_W = $clog2(N_BIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  op_e              accept_op,
  input  logic             ext_fit,
  input  logic             sup_fit,
  input  logic             legacy,
  input  logic [N_BIT-1:0] ack,
  input  logic [N_BIT-1:0] fail,
  input  logic             tmr_expired,
  output logic             tmr_start,
  output logic             waiting,
  output logic             busy,
  output logic [N_BIT-1:0] en_q,
  output logic             done_q,
  output logic             err_q,
  output logic             load_q,
  output logic [IDX_W-1:0] err_step_q,
  output logic             err_tmo_q
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STEP - 1);

  st_e              st_q;
  op_e              op_q;
  logic [IDX_W-1:0] idx_q;
  logic             failed_q;
  logic             armed_q;

  logic [BIT_W-1:0] cur_bit;
  logic             fitted;
  logic             at_last;
  logic             ack_hit;
  logic             fail_hit;
  logic             ev_good;
  logic             ev_bad;
  logic             ev_finish;
  logic             finish_err;

  always_comb begin
    cur_bit   = BIT_W'(flat_bit(op_q, 32'(idx_q), N_STEP));
    fitted    = step_fitted(op_q, 32'(idx_q), N_STEP - 1, ext_fit, sup_fit);
    at_last   = (idx_q == LAST);
    waiting   = (st_q == ST_WAIT);
    busy      = (st_q != ST_IDLE);
    ack_hit   = ack[cur_bit];
    fail_hit  = fail[cur_bit];
    ev_bad    = waiting && (fail_hit || (tmr_expired && !ack_hit));
    ev_good   = waiting && ack_hit && !fail_hit;
    tmr_start = (st_q == ST_ISSUE) && fitted;
  end

  always_comb begin
    ev_finish  = 1'b0;
    finish_err = 1'b0;
    unique case (st_q)
      ST_ISSUE: ev_finish = !fitted && at_last;
      ST_WAIT: begin
        if (ev_bad) begin
          ev_finish  = (idx_q == '0);
          finish_err = 1'b1;
        end else if (ev_good) begin
          ev_finish = at_last;
        end
      end
      ST_DOWN: begin
        ev_finish  = (idx_q == '0);
        finish_err = failed_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_INIT;
      idx_q      <= '0;
      en_q       <= '0;
      failed_q   <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      load_q     <= 1'b0;
      err_step_q <= '0;
      err_tmo_q  <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      done_q  <= ev_finish;
      err_q   <= ev_finish && finish_err;
      load_q  <= ev_finish && !finish_err && (op_q == OP_INIT) && !legacy;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q       <= accept_op;
            failed_q   <= 1'b0;
            err_step_q <= '0;
            err_tmo_q  <= 1'b0;
            if (op_is_up(accept_op)) begin
              idx_q <= '0;
              st_q  <= ST_ISSUE;
            end else begin
              idx_q <= LAST;
              st_q  <= ST_DOWN;
            end
          end
        end
        ST_ISSUE: begin
          if (fitted) begin
            en_q[cur_bit] <= 1'b1;
            st_q          <= ST_WAIT;
          end else if (!at_last) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ev_bad) begin
            en_q[cur_bit] <= 1'b0;
            err_step_q    <= idx_q;
            err_tmo_q     <= !fail_hit;
            failed_q      <= 1'b1;
            if (idx_q != '0) begin
              idx_q <= idx_q - 1'b1;
              st_q  <= ST_DOWN;
            end
          end else if (ev_good && !at_last) begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_ISSUE;
          end
        end
        ST_DOWN: begin
          en_q[cur_bit] <= 1'b0;
          if (idx_q != '0) idx_q <= idx_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (ev_finish) st_q <= ST_IDLE;
    end
  end

  // R2: a bring-up never raises more than one control in a cycle
  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ($countones(en_q & ~$past(en_q)) <= 1));

  // R3: tear-down and unwind cycles only ever lower controls
  p_down_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DOWN) |=> ((en_q & ~$past(en_q)) == '0));

  // R6: a failed step loses its enable on the following cycle
  p_bad_step_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> ($countones(en_q) < $countones($past(en_q))));

  // R8: without an accepted command the controls stay put while idle
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !accept) |=> $stable(en_q));

  // R10: completion is reported for exactly one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int N_STEP = 4,
  parameter int TMO_W  = 8,
  localparam int N_BIT = 2 * N_STEP,
  localparam int IDX_W = $clog2(N_STEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_init_i,
  input  logic             cmd_exit_i,
  input  logic             cmd_on_i,
  input  logic             cmd_off_i,
  input  logic             ext_clk_fitted_i,
  input  logic             bus_sup_fitted_i,
  input  logic             legacy_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic [N_BIT-1:0] ack_i,
  input  logic [N_BIT-1:0] fail_i,
  output logic [N_BIT-1:0] en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] err_step_o,
  output logic             err_tmo_o,
  output logic             reject_o,
  output logic             load_o
);

  logic accept;
  op_e  accept_op;
  logic tmr_start;
  logic tmr_expired;
  logic waiting;
  logic any_cmd;

  assign any_cmd = cmd_init_i | cmd_exit_i | cmd_on_i | cmd_off_i;

  phy_seq_cmd_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_init  (cmd_init_i),
    .cmd_exit  (cmd_exit_i),
    .cmd_on    (cmd_on_i),
    .cmd_off   (cmd_off_i),
    .idle      (!busy_o),
    .accept    (accept),
    .accept_op (accept_op),
    .reject_q  (reject_o)
  );

  phy_seq_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .run     (waiting),
    .limit   (tmo_limit_i),
    .expired (tmr_expired)
  );

  phy_seq_ctrl #(.N_STEP(N_STEP)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .accept_op   (accept_op),
    .ext_fit     (ext_clk_fitted_i),
    .sup_fit     (bus_sup_fitted_i),
    .legacy      (legacy_i),
    .ack         (ack_i),
    .fail        (fail_i),
    .tmr_expired (tmr_expired),
    .tmr_start   (tmr_start),
    .waiting     (waiting),
    .busy        (busy_o),
    .en_q        (en_o),
    .done_q      (done_o),
    .err_q       (err_o),
    .load_q      (load_o),
    .err_step_q  (err_step_o),
    .err_tmo_q   (err_tmo_o)
  );

  // R7: an expired wait never continues into another wait cycle
  p_tmo_ends_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expired |=> !waiting);

  // R8: a command during a running sequence is always refused
  p_busy_cmd_rejected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && any_cmd) |=> reject_o);

  // R9: loader start only accompanies a clean completion outside legacy mode
  p_load_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (done_o && !err_o && !$past(legacy_i)));

endmodule

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_init = 1'b0, cmd_exit = 1'b0, cmd_on = 1'b0, cmd_off = 1'b0;
  logic       ext_fit = 1'b1, sup_fit = 1'b1, legacy = 1'b0;
  logic [7:0] tmo_lim = 8'd20;
  logic [7:0] ack_r = '0, fail_r = '0;

  logic [7:0] en_o;
  logic       busy_o, done_o, err_o, err_tmo_o, reject_o, load_o;
  logic [1:0] err_step_o;

  always #4 clk = ~clk;

  phy_pwr_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_init_i(cmd_init), .cmd_exit_i(cmd_exit), .cmd_on_i(cmd_on), .cmd_off_i(cmd_off),
    .ext_clk_fitted_i(ext_fit), .bus_sup_fitted_i(sup_fit), .legacy_i(legacy),
    .tmo_limit_i(tmo_lim), .ack_i(ack_r), .fail_i(fail_r),
    .en_o(en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .err_step_o(err_step_o), .err_tmo_o(err_tmo_o), .reject_o(reject_o), .load_o(load_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int         m_st = 0;     // 0 idle, 1 raise, 2 wait, 3 lower
  int         m_op = 0;     // 0 init, 1 exit, 2 on, 3 off
  int         m_idx = 0;
  int         m_wc = 0;
  bit         m_failed = 0;
  logic [7:0] m_en = '0;
  bit         m_done = 0, m_err = 0, m_load = 0, m_rej = 0, m_etmo = 0;
  int         m_estep = 0;

  function automatic int m_bit();
    return (m_op < 2) ? 4 + m_idx : m_idx;
  endfunction

  function automatic bit m_present();
    if (m_op < 2) return 1;
    if (m_idx == 0) return ext_fit;
    if (m_idx == 3) return sup_fit;
    return 1;
  endfunction

  task automatic m_finish(input bit e);
    m_st   = 0;
    m_done = 1;
    m_err  = e;
    m_load = !e && (m_op == 0) && !legacy;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_op = 0; m_idx = 0; m_wc = 0; m_failed = 0; m_en = '0;
      m_done = 0; m_err = 0; m_load = 0; m_rej = 0; m_etmo = 0; m_estep = 0;
    end else begin
      int nc;
      int b;
      bit ah, fh;
      nc = int'(cmd_init) + int'(cmd_exit) + int'(cmd_on) + int'(cmd_off);
      m_rej  = (nc > 0) && ((m_st != 0) || (nc > 1));
      m_done = 0; m_err = 0; m_load = 0;
      b = m_bit();
      case (m_st)
        0: if (nc == 1) begin
             m_op = cmd_init ? 0 : cmd_exit ? 1 : cmd_on ? 2 : 3;
             m_failed = 0; m_estep = 0; m_etmo = 0;
             if (m_op == 0 || m_op == 2) begin m_idx = 0; m_st = 1; end
             else begin m_idx = 3; m_st = 3; end
           end
        1: if (m_present()) begin m_en[b] = 1'b1; m_wc = 0; m_st = 2; end
           else if (m_idx == 3) m_finish(0);
           else m_idx++;
        2: begin
             ah = ack_r[b]; fh = fail_r[b];
             if (fh || (m_wc == int'(tmo_lim) && !ah)) begin
               m_en[b] = 1'b0; m_estep = m_idx; m_etmo = !fh; m_failed = 1;
               if (m_idx == 0) m_finish(1);
               else begin m_idx--; m_st = 3; end
             end else if (ah) begin
               if (m_idx == 3) m_finish(0);
               else begin m_idx++; m_st = 1; end
             end else m_wc++;
           end
        default: begin
             m_en[b] = 1'b0;
             if (m_idx == 0) m_finish(m_failed);
             else m_idx--;
           end
      endcase
    end
  end

  // ---------------- resource responder, logger, comparison ----------------
  int         rk[8];       // 0 ack, 1 fail, 2 silent, 3 ack and fail together
  int         rd[8];       // delay from seeing the enable to the answer
  bit         rs_on[8];
  int         rs_cnt[8];
  logic [7:0] prev_en = '0;
  int         rcode = 0, fcode = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "en_o",       int'(en_o),       int'(m_en));
      chk("R8", "busy_o",     int'(busy_o),     int'(m_st != 0));
      chk("R10", "done_o",    int'(done_o),     int'(m_done));
      chk("R6", "err_o",      int'(err_o),      int'(m_err));
      chk("R9", "load_o",     int'(load_o),     int'(m_load));
      chk("R8", "reject_o",   int'(reject_o),   int'(m_rej));
      chk("R6", "err_step_o", int'(err_step_o), m_estep);
      chk("R7", "err_tmo_o",  int'(err_tmo_o),  int'(m_etmo));
    end
    for (int i = 0; i < 8; i++) begin
      if (en_o[i] && !prev_en[i]) rcode = rcode * 10 + (i + 1);
      if (!en_o[i] && prev_en[i]) fcode = fcode * 10 + (i + 1);
    end
    prev_en = en_o;
    for (int i = 0; i < 8; i++) begin
      ack_r[i]  = 1'b0;
      fail_r[i] = 1'b0;
      if (en_o[i] && !rs_on[i]) begin rs_on[i] = 1; rs_cnt[i] = rd[i]; end
      else if (!en_o[i]) begin rs_on[i] = 0; rs_cnt[i] = -1; end
      if (rs_on[i] && rs_cnt[i] == 0) begin
        ack_r[i]  = (rk[i] == 0) || (rk[i] == 3);
        fail_r[i] = (rk[i] == 1) || (rk[i] == 3);
        rs_cnt[i] = -1;
      end else if (rs_on[i] && rs_cnt[i] > 0) begin
        rs_cnt[i]--;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  int d_err, d_load, d_step, d_tmo, d_lat;

  task automatic pulse_cmd(input bit i, input bit e, input bit o, input bit f);
    @(negedge clk);
    cmd_init = i; cmd_exit = e; cmd_on = o; cmd_off = f;
    @(negedge clk);
    cmd_init = 0; cmd_exit = 0; cmd_on = 0; cmd_off = 0;
  endtask

  task automatic wait_done(input string tag);
    d_lat = 0;
    while (!done_o && d_lat < 400) begin
      @(negedge clk);
      d_lat++;
    end
    chk(tag, "sequence completes", int'(done_o), 1);
    d_err = int'(err_o); d_load = int'(load_o);
    d_step = int'(err_step_o); d_tmo = int'(err_tmo_o);
    @(negedge clk);
  endtask

  task automatic set_resp(input int kind, input int dly);
    for (int i = 0; i < 8; i++) begin rk[i] = kind; rd[i] = dly; end
  endtask

  task automatic clear_codes();
    rcode = 0; fcode = 0;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < 8; i++) begin rs_on[i] = 0; rs_cnt[i] = -1; end
    set_resp(0, 0);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "en_o at reset", int'(en_o), 0);
    chk("R1", "busy_o at reset", int'(busy_o), 0);
    chk("R1", "done/err/load/reject at reset", int'({done_o, err_o, load_o, reject_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset release", int'(busy_o), 0);

    // R4 + R9: init with mixed delays
    rd[4] = 0; rd[5] = 2; rd[6] = 1; rd[7] = 3;
    clear_codes();
    pulse_cmd(1, 0, 0, 0);
    wait_done("R4");
    chk("R4", "init rise order", rcode, 5678);
    chk("R9", "loader start after init", d_load, 1);
    chk("R4", "init no error", d_err, 0);

    // R4: exit order
    clear_codes();
    pulse_cmd(0, 1, 0, 0);
    wait_done("R4");
    chk("R4", "exit fall order", fcode, 8765);
    chk("R9", "no loader start after exit", d_load, 0);

    // R2 + R8: power-on with a refused init in the middle
    rd[0] = 1; rd[1] = 0; rd[2] = 2; rd[3] = 1;
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    pulse_cmd(1, 0, 0, 0);
    chk("R8", "reject while busy", int'(reject_o), 1);
    wait_done("R2");
    chk("R2", "power-on rise order", rcode, 1234);
    chk("R8", "refused init left link group", int'(en_o[7:4]), 0);

    // R8: two commands at once in idle
    pulse_cmd(1, 0, 0, 1);
    chk("R8", "reject on double command", int'(reject_o), 1);
    @(negedge clk);
    chk("R8", "double command not started", int'(busy_o), 0);
    chk("R8", "double command changed nothing", int'(en_o), 15);

    // R3: power-off order and latency
    clear_codes();
    pulse_cmd(0, 0, 0, 1);
    wait_done("R3");
    chk("R3", "power-off fall order", fcode, 4321);
    chk("R3", "power-off cycles", d_lat, 4);

    // R5: optional resources absent
    ext_fit = 0; sup_fit = 0; set_resp(0, 1);
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    wait_done("R5");
    chk("R5", "only fitted steps raised", rcode, 23);
    chk("R5", "optional enables low", int'({en_o[3], en_o[0]}), 0);
    clear_codes();
    pulse_cmd(0, 0, 0, 1);
    wait_done("R5");
    chk("R5", "fitted steps lowered", fcode, 32);
    ext_fit = 1; sup_fit = 1;

    // R6: failure at step 2
    set_resp(0, 0); rk[2] = 1; rd[2] = 2;
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    wait_done("R6");
    chk("R6", "rises before failure", rcode, 123);
    chk("R6", "unwind order", fcode, 321);
    chk("R6", "error flagged", d_err, 1);
    chk("R6", "failed step index", d_step, 2);
    chk("R6", "cause is failure", d_tmo, 0);
    chk("R6", "all power enables low", int'(en_o), 0);

    // R7 + R10: silent step 1 with limit 5
    set_resp(0, 0); rk[1] = 2; tmo_lim = 8'd5;
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    wait_done("R7");
    chk("R7", "timeout unwind order", fcode, 21);
    chk("R7", "timeout cause", d_tmo, 1);
    chk("R7", "timeout step", d_step, 1);
    repeat (3) @(negedge clk);
    chk("R10", "cause held", int'(err_tmo_o), 1);
    chk("R10", "step held", int'(err_step_o), 1);
    chk("R10", "done not held", int'(done_o), 0);

    // R11: answer in the last allowed wait cycle is accepted
    set_resp(0, 0); tmo_lim = 8'd3; rd[1] = 3;
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    wait_done("R11");
    chk("R11", "ack at limit accepted", d_err, 0);
    chk("R11", "all steps raised", rcode, 1234);
    pulse_cmd(0, 0, 0, 1);
    wait_done("R3");

    // R7: answer one cycle past the limit is a timeout
    set_resp(0, 0); rd[2] = 4;
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    wait_done("R7");
    chk("R7", "late ack times out", d_tmo, 1);
    chk("R7", "late ack step", d_step, 2);
    chk("R7", "late ack unwind", fcode, 321);

    // R11: ack and fail together count as failure
    set_resp(0, 0); rk[3] = 3; tmo_lim = 8'd20;
    clear_codes();
    pulse_cmd(0, 0, 1, 0);
    wait_done("R11");
    chk("R11", "fail wins over ack", d_err, 1);
    chk("R11", "fail cause", d_tmo, 0);
    chk("R11", "unwind from last step", fcode, 4321);

    // R9: legacy init gives no loader start
    set_resp(0, 1); legacy = 1;
    pulse_cmd(1, 0, 0, 0);
    wait_done("R9");
    chk("R9", "legacy no loader start", d_load, 0);
    chk("R9", "legacy init clean", d_err, 0);
    pulse_cmd(0, 1, 0, 0);
    wait_done("R4");
    legacy = 0;

    // R6: init failure at secondary bus clock
    set_resp(0, 0); rk[5] = 1;
    clear_codes();
    pulse_cmd(1, 0, 0, 0);
    wait_done("R6");
    chk("R6", "init rises before failure", rcode, 56);
    chk("R6", "init unwind", fcode, 65);
    chk("R6", "init failed step", d_step, 1);
    chk("R9", "no loader start after failed init", d_load, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule